// File: doc/BRIEF.md
# Ethernet Pause Flow Controller

This block holds the flow-control logic of a 10/100 Ethernet MAC in one control/status byte. In full duplex it asks the transmitter for pause frames. Software can arm a one-shot request with a pause time of FFFFh or 0000h, and each request clears itself once its frame has gone out. When automatic mode is on, the block also asks for pause frames as the receive buffer crosses its high and low watermarks. When a peer's pause frame arrives, the block loads the received quanta into a countdown. While the countdown is non-zero and flow control is enabled, it holds the transmitter halted.

In half duplex no pause frames are requested. Instead, a back-pressure jam strobe can be raised when the receive buffer is above its back-pressure threshold. One mode jams on every incoming frame. The other jams only when the frame's destination address matches. The transmitter is expected to build the pause frame from `tx_pause_time` and to pulse `tx_pause_done` in a cycle where `tx_pause_req` is high.

Top module: `pause_flow_ctrl`

## Requirements
- R1: The control byte reads back as {bit7 zero-time trigger, bit6 max-time trigger, bit5 auto enable, bit4 jam-on-any mode, bit3 jam-on-address-match mode, bit2 pause-in-effect, bit1 received-pause latch, bit0 flow-control enable}. A write loads bits 0, 3, 4 and 5. Written values of bits 1 and 2 are ignored. After reset the byte reads 00h.
- R2: Writing 1 to bit 6 arms a request with pause time FFFFh. Bit 6 reads 1 until the transmitter accepts that frame, then it clears. Writing 0 to bit 6 does not cancel the request.
- R3: Writing 1 to bit 7 arms a request with pause time 0000h, which clears itself in the same way.
- R4: When both the FFFFh and 0000h requests are pending, the FFFFh frame is requested first and the 0000h frame is requested after it.
- R5: A pause request stays high, with an unchanged pause time, until `tx_pause_done` is seen with it. It drops the cycle after acceptance.
- R6: With auto enabled, the high watermark produces exactly one FFFFh request. A later low watermark produces exactly one 0000h request. No further request is made until the opposite watermark is reached.
- R7: A received pause sets bit 1. A read with `reg_rd_en` clears bit 1, unless a received pause arrives in the same cycle.
- R8: A received pause loads its quanta into a countdown that drops by one every PRESCALE slot ticks. A new pause reloads it. Bit 2 is 1 while the count is non-zero. `tx_halt` is high while the count is non-zero and bit 0 is set.
- R9: A received pause with quanta 0 releases the halt in the next cycle.
- R10: While `half_duplex` is high, no pause request is shown, and pending requests wait until it falls. `jam_req` and `tx_pause_req` are never high together.
- R11: In half duplex with bit 4 set, `rx_frame_start` while `rx_bp_hi` is high gives a one-cycle `jam_req` in the next cycle. Without `rx_bp_hi` there is no jam.
- R12: In half duplex with bit 3 set, only `rx_da_match` while `rx_bp_hi` is high gives the jam strobe. A frame start alone does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write strobe for the control byte |
| reg_wdata | input | 8 | Write data |
| reg_rd_en | input | 1 | Read strobe; clears the received-pause latch |
| reg_rdata | output | 8 | Current control/status byte |
| half_duplex | input | 1 | Link runs half duplex |
| rx_hi_wm | input | 1 | RX buffer at or above the high watermark |
| rx_lo_wm | input | 1 | RX buffer below the low watermark |
| rx_bp_hi | input | 1 | RX buffer above the back-pressure threshold |
| rx_frame_start | input | 1 | Strobe: incoming frame begins |
| rx_da_match | input | 1 | Strobe: incoming destination address matched |
| rx_pause_valid | input | 1 | Strobe: pause frame received |
| rx_pause_quanta | input | 16 | Pause time of the received frame |
| slot_tick | input | 1 | One pulse per 512 bit times |
| tx_pause_done | input | 1 | Transmitter accepts the requested pause frame |
| tx_pause_req | output | 1 | Pause frame transmit request |
| tx_pause_time | output | 16 | Pause time for the requested frame |
| tx_halt | output | 1 | Suspend normal transmission |
| jam_req | output | 1 | Half-duplex jam strobe |

## Verification
The bench builds the block with PRESCALE set to 2, so the countdown needs two slot ticks per quantum. A change in the prescaler counter's reset or wrap therefore shows up in when the halt releases. Small quanta such as 3 bring the release within a few dozen cycles. The FFFFh and 0000h pause times are reached through the triggers, and the bench compares both values on every requested frame.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    localparam int QW = 16;
    localparam logic [QW-1:0] PT_MAX  = 16'hFFFF;
    localparam logic [QW-1:0] PT_ZERO = 16'h0000;

    // control byte bit positions
    localparam int B_FLOW  = 0;
    localparam int B_RXST  = 1;
    localparam int B_PNOW  = 2;
    localparam int B_BPDA  = 3;
    localparam int B_BPANY = 4;
    localparam int B_AUTO  = 5;
    localparam int B_TMAX  = 6;
    localparam int B_TZERO = 7;

    typedef enum logic {
        PK_ZERO = 1'b0,
        PK_MAX  = 1'b1
    } pkind_e;

    typedef struct packed {
        logic trig_zero;
        logic trig_max;
        logic auto_en;
        logic bp_any;
        logic bp_da;
        logic flow_en;
    } ctrl_t;

    function automatic logic [QW-1:0] kind_time(input pkind_e k);
        return (k == PK_MAX) ? PT_MAX : PT_ZERO;
    endfunction

endpackage

// File: rtl/pfc_regs.sv
module pfc_regs
    import pfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic       rd_en,
    input  logic       rx_pause_seen,
    input  logic       pause_now,
    input  logic       clr_max,
    input  logic       clr_zero,
    output ctrl_t      ctrl,
    output logic [7:0] rdata
);
    logic rx_latched;
    logic ro_unused;

    assign ro_unused = wdata[B_RXST] | wdata[B_PNOW];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.flow_en <= 1'b0;
            ctrl.bp_da   <= 1'b0;
            ctrl.bp_any  <= 1'b0;
            ctrl.auto_en <= 1'b0;
        end else if (wr_en) begin
            ctrl.flow_en <= wdata[B_FLOW];
            ctrl.bp_da   <= wdata[B_BPDA];
            ctrl.bp_any  <= wdata[B_BPANY];
            ctrl.auto_en <= wdata[B_AUTO];
        end
    end

    // one-shot triggers: a write of 1 arms, acceptance of the frame disarms
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.trig_max  <= 1'b0;
            ctrl.trig_zero <= 1'b0;
        end else begin
            ctrl.trig_max  <= (ctrl.trig_max  & ~clr_max)  | (wr_en & wdata[B_TMAX]);
            ctrl.trig_zero <= (ctrl.trig_zero & ~clr_zero) | (wr_en & wdata[B_TZERO]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                rx_latched <= 1'b0;
        else if (rx_pause_seen) rx_latched <= 1'b1;
        else if (rd_en)         rx_latched <= 1'b0;
    end

    always_comb begin
        rdata          = '0;
        rdata[B_FLOW]  = ctrl.flow_en;
        rdata[B_RXST]  = rx_latched;
        rdata[B_PNOW]  = pause_now;
        rdata[B_BPDA]  = ctrl.bp_da;
        rdata[B_BPANY] = ctrl.bp_any;
        rdata[B_AUTO]  = ctrl.auto_en;
        rdata[B_TMAX]  = ctrl.trig_max;
        rdata[B_TZERO] = ctrl.trig_zero;
    end

endmodule

// File: rtl/pfc_pause_tx.sv
module pfc_pause_tx
    import pfc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  ctrl_t         ctrl,
    input  logic          half_duplex,
    input  logic          hi_wm,
    input  logic          lo_wm,
    input  logic          tx_done,
    output logic          req,
    output logic [QW-1:0] ptime,
    output logic          clr_max,
    output logic          clr_zero
);
    logic   xoff_state;
    logic   xoff_pend;
    logic   xon_pend;
    logic   active;
    pkind_e kind;
    logic   want_max;
    logic   want_zero;
    logic   finish;

    assign want_max  = ctrl.trig_max  | xoff_pend;
    assign want_zero = ctrl.trig_zero | xon_pend;
    assign finish    = active & ~half_duplex & tx_done;
    assign clr_max   = finish & (kind == PK_MAX);
    assign clr_zero  = finish & (kind == PK_ZERO);

    // watermark tracker: one request per crossing
    always_ff @(posedge clk) begin
        if (rst || !ctrl.auto_en) begin
            xoff_state <= 1'b0;
            xoff_pend  <= 1'b0;
            xon_pend   <= 1'b0;
        end else begin
            if (clr_max)  xoff_pend <= 1'b0;
            if (clr_zero) xon_pend  <= 1'b0;
            if (hi_wm && !xoff_state) begin
                xoff_state <= 1'b1;
                xoff_pend  <= 1'b1;
            end else if (lo_wm && xoff_state) begin
                xoff_state <= 1'b0;
                xon_pend   <= 1'b1;
            end
        end
    end

    // launcher: FFFFh requests take precedence over 0000h requests
    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            kind   <= PK_ZERO;
        end else if (half_duplex) begin
            active <= 1'b0;
        end else if (active) begin
            if (tx_done) active <= 1'b0;
        end else if (want_max) begin
            active <= 1'b1;
            kind   <= PK_MAX;
        end else if (want_zero) begin
            active <= 1'b1;
            kind   <= PK_ZERO;
        end
    end

    assign req   = active & ~half_duplex;
    assign ptime = kind_time(kind);

endmodule

// File: rtl/pfc_halt_timer.sv
module pfc_halt_timer
    import pfc_pkg::*;
#(
    parameter int PRESCALE = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [QW-1:0] quanta,
    input  logic          slot_tick,
    input  logic          flow_en,
    output logic          pause_now,
    output logic          halt
);
    logic [QW-1:0] cnt;
    logic          step;

    generate
        if (PRESCALE <= 1) begin : g_direct
            assign step = slot_tick;
        end else begin : g_prescale
            localparam int PRE_W = $clog2(PRESCALE);
            localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
            logic [PRE_W-1:0] pre;
            always_ff @(posedge clk) begin
                if (rst || load)                     pre <= '0;
                else if (slot_tick && cnt != '0) begin
                    if (pre == PRE_LAST)             pre <= '0;
                    else                             pre <= pre + 1'b1;
                end
            end
            assign step = slot_tick && (pre == PRE_LAST);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)                     cnt <= '0;
        else if (load)               cnt <= quanta;
        else if (step && cnt != '0)  cnt <= cnt - 16'd1;
    end

    assign pause_now = (cnt != '0);
    assign halt      = flow_en & pause_now;

endmodule

// File: rtl/pfc_jam.sv
module pfc_jam (
    input  logic clk,
    input  logic rst,
    input  logic half_duplex,
    input  logic bp_hi,
    input  logic frame_start,
    input  logic da_match,
    input  logic mode_any,
    input  logic mode_da,
    output logic jam_req
);
    logic jam_q;
    logic hit;

    assign hit = (mode_any & frame_start) | (mode_da & da_match);

    always_ff @(posedge clk) begin
        if (rst) jam_q <= 1'b0;
        else     jam_q <= half_duplex & bp_hi & hit;
    end

    assign jam_req = jam_q & half_duplex;

endmodule

// File: rtl/pause_flow_ctrl.sv
module pause_flow_ctrl
    import pfc_pkg::*;
#(
    parameter int PRESCALE = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr_en,
    input  logic [7:0]    reg_wdata,
    input  logic          reg_rd_en,
    output logic [7:0]    reg_rdata,
    input  logic          half_duplex,
    input  logic          rx_hi_wm,
    input  logic          rx_lo_wm,
    input  logic          rx_bp_hi,
    input  logic          rx_frame_start,
    input  logic          rx_da_match,
    input  logic          rx_pause_valid,
    input  logic [15:0]   rx_pause_quanta,
    input  logic          slot_tick,
    input  logic          tx_pause_done,
    output logic          tx_pause_req,
    output logic [15:0]   tx_pause_time,
    output logic          tx_halt,
    output logic          jam_req
);
    ctrl_t ctrl;
    logic  pause_now;
    logic  clr_max;
    logic  clr_zero;

    pfc_regs u_regs (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (reg_wr_en),
        .wdata         (reg_wdata),
        .rd_en         (reg_rd_en),
        .rx_pause_seen (rx_pause_valid),
        .pause_now     (pause_now),
        .clr_max       (clr_max),
        .clr_zero      (clr_zero),
        .ctrl          (ctrl),
        .rdata         (reg_rdata)
    );

    pfc_pause_tx u_ptx (
        .clk         (clk),
        .rst         (rst),
        .ctrl        (ctrl),
        .half_duplex (half_duplex),
        .hi_wm       (rx_hi_wm),
        .lo_wm       (rx_lo_wm),
        .tx_done     (tx_pause_done),
        .req         (tx_pause_req),
        .ptime       (tx_pause_time),
        .clr_max     (clr_max),
        .clr_zero    (clr_zero)
    );

    pfc_halt_timer #(.PRESCALE(PRESCALE)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .load      (rx_pause_valid),
        .quanta    (rx_pause_quanta),
        .slot_tick (slot_tick),
        .flow_en   (ctrl.flow_en),
        .pause_now (pause_now),
        .halt      (tx_halt)
    );

    pfc_jam u_jam (
        .clk         (clk),
        .rst         (rst),
        .half_duplex (half_duplex),
        .bp_hi       (rx_bp_hi),
        .frame_start (rx_frame_start),
        .da_match    (rx_da_match),
        .mode_any    (ctrl.bp_any),
        .mode_da     (ctrl.bp_da),
        .jam_req     (jam_req)
    );

endmodule

// File: rtl/pfc_checker.sv
module pfc_checker (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr_en,
    input logic [7:0]  reg_rdata,
    input logic        half_duplex,
    input logic        rx_bp_hi,
    input logic        rx_pause_valid,
    input logic [15:0] rx_pause_quanta,
    input logic        tx_pause_done,
    input logic        tx_pause_req,
    input logic [15:0] tx_pause_time,
    input logic        tx_halt,
    input logic        jam_req
);
    assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(jam_req && tx_pause_req));

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (tx_pause_req && !tx_pause_done) |=> (tx_pause_req || half_duplex));

    assert_time_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (tx_pause_req && !tx_pause_done) |=> $stable(tx_pause_time));

    assert_zero_release_R9: assert property (@(posedge clk) disable iff (rst)
        (rx_pause_valid && rx_pause_quanta == 16'd0) |=> !tx_halt);

    assert_halt_load_R8: assert property (@(posedge clk) disable iff (rst)
        (rx_pause_valid && rx_pause_quanta != 16'd0 && reg_rdata[0] && !reg_wr_en) |=> tx_halt);

    assert_latch_R7: assert property (@(posedge clk) disable iff (rst)
        rx_pause_valid |=> reg_rdata[1]);

    assert_jam_cause_R11: assert property (@(posedge clk) disable iff (rst)
        jam_req |-> $past(rx_bp_hi));

endmodule

bind pause_flow_ctrl pfc_checker u_pfc_checker (
    .clk             (clk),
    .rst             (rst),
    .reg_wr_en       (reg_wr_en),
    .reg_rdata       (reg_rdata),
    .half_duplex     (half_duplex),
    .rx_bp_hi        (rx_bp_hi),
    .rx_pause_valid  (rx_pause_valid),
    .rx_pause_quanta (rx_pause_quanta),
    .tx_pause_done   (tx_pause_done),
    .tx_pause_req    (tx_pause_req),
    .tx_pause_time   (tx_pause_time),
    .tx_halt         (tx_halt),
    .jam_req         (jam_req)
);

// File: tb/test_pause_flow_ctrl.sv
module test_pause_flow_ctrl;
    localparam int PRESCALE = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 0, reg_rd_en = 0;
    logic [7:0]  reg_wdata = 0;
    logic [7:0]  reg_rdata;
    logic        half_duplex = 0, rx_hi_wm = 0, rx_lo_wm = 0, rx_bp_hi = 0;
    logic        rx_frame_start = 0, rx_da_match = 0, rx_pause_valid = 0;
    logic [15:0] rx_pause_quanta = 0;
    logic        slot_tick = 0, tx_pause_done = 0;
    logic        tx_pause_req, tx_halt, jam_req;
    logic [15:0] tx_pause_time;

    always #5 clk = ~clk;

    pause_flow_ctrl #(.PRESCALE(PRESCALE)) i_pause_flow_ctrl (.*);

    int total = 0;
    int bad = 0;
    bit ack_on = 0;
    logic [15:0] obs[$];

    // behavioural reference state
    bit m_flow, m_rxst, m_bpda, m_bpany, m_auto, m_tmax, m_tzero;
    bit m_xs, m_xoffp, m_xonp, m_act, m_kmax, m_jam;
    int m_cnt, m_pre;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        bit fin, cmax, czero, wm, wz;
        if (rst) begin
            {m_flow, m_rxst, m_bpda, m_bpany, m_auto, m_tmax, m_tzero} = '0;
            {m_xs, m_xoffp, m_xonp, m_act, m_kmax, m_jam} = '0;
            m_cnt = 0; m_pre = 0;
            return;
        end
        fin   = m_act && !half_duplex && tx_pause_done;
        cmax  = fin && m_kmax;
        czero = fin && !m_kmax;
        wm    = m_tmax || m_xoffp;
        wz    = m_tzero || m_xonp;
        // auto tracker uses the enable held before this edge
        if (!m_auto) begin
            m_xs = 0; m_xoffp = 0; m_xonp = 0;
        end else begin
            if (cmax)  m_xoffp = 0;
            if (czero) m_xonp = 0;
            if (rx_hi_wm && !m_xs)     begin m_xs = 1; m_xoffp = 1; end
            else if (rx_lo_wm && m_xs) begin m_xs = 0; m_xonp = 1; end
        end
        if (half_duplex)  m_act = 0;
        else if (m_act)   m_act = !tx_pause_done;
        else if (wm)      begin m_act = 1; m_kmax = 1; end
        else if (wz)      begin m_act = 1; m_kmax = 0; end
        m_jam = half_duplex && rx_bp_hi &&
                ((m_bpany && rx_frame_start) || (m_bpda && rx_da_match));
        m_tmax  = (m_tmax && !cmax)   || (reg_wr_en && reg_wdata[6]);
        m_tzero = (m_tzero && !czero) || (reg_wr_en && reg_wdata[7]);
        if (reg_wr_en) begin
            m_flow = reg_wdata[0]; m_bpda = reg_wdata[3];
            m_bpany = reg_wdata[4]; m_auto = reg_wdata[5];
        end
        if (rx_pause_valid) m_rxst = 1;
        else if (reg_rd_en) m_rxst = 0;
        if (rx_pause_valid) begin
            m_cnt = int'(rx_pause_quanta); m_pre = 0;
        end else if (slot_tick && m_cnt > 0) begin
            if (m_pre == PRESCALE - 1) begin m_pre = 0; m_cnt--; end
            else m_pre++;
        end
    endtask

    task automatic compare();
        bit exp_req;
        logic [7:0] exp_rd;
        exp_req = m_act && !half_duplex;
        exp_rd  = {m_tzero, m_tmax, m_auto, m_bpany, m_bpda, (m_cnt != 0), m_rxst, m_flow};
        chk(tx_pause_req == exp_req, "R5 request level", 32'(tx_pause_req), 32'(exp_req));
        if (exp_req)
            chk(tx_pause_time == (m_kmax ? 16'hFFFF : 16'h0000), "R2 R3 pause time",
                32'(tx_pause_time), m_kmax ? 32'hFFFF : 32'h0);
        chk(tx_halt == (m_flow && m_cnt != 0), "R8 halt level", 32'(tx_halt), 32'(m_flow && m_cnt != 0));
        chk(jam_req == (m_jam && half_duplex), "R11 jam level", 32'(jam_req), 32'(m_jam && half_duplex));
        chk(reg_rdata == exp_rd, "R1 control byte", 32'(reg_rdata), 32'(exp_rd));
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        #1;
        compare();
        tx_pause_done = ack_on && tx_pause_req;
        if (tx_pause_done) obs.push_back(tx_pause_time);
    endtask

    task automatic run(input int n);
        repeat (n) step();
    endtask

    task automatic wr(input logic [7:0] v);
        reg_wr_en = 1; reg_wdata = v; step(); reg_wr_en = 0;
    endtask

    task automatic rx_pause(input logic [15:0] q);
        rx_pause_valid = 1; rx_pause_quanta = q; step(); rx_pause_valid = 0;
    endtask

    task automatic tick();
        slot_tick = 1; step(); slot_tick = 0; step();
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        run(3);
        rst = 0;
        step();
        chk(reg_rdata == 8'h00 && !tx_pause_req && !tx_halt && !jam_req, "R1 reset state", 32'(reg_rdata), 0);

        // R1: RW bits and ignored status bits
        wr(8'h39);
        chk(reg_rdata == 8'h39, "R1 readback", 32'(reg_rdata), 32'h39);
        wr(8'h06);
        chk(reg_rdata == 8'h00, "R1 status bits ignore writes", 32'(reg_rdata), 0);

        // R2 and R5: FFFFh trigger held until accepted
        ack_on = 0; obs.delete();
        wr(8'h40);
        run(2);
        chk(tx_pause_req && tx_pause_time == 16'hFFFF, "R2 max request", 32'(tx_pause_time), 32'hFFFF);
        wr(8'h00);
        run(3);
        chk(tx_pause_req && reg_rdata[6], "R5 request held, R2 not cancelled by 0", 32'(reg_rdata), 32'h40);
        ack_on = 1;
        run(3);
        chk(obs.size() == 1 && !reg_rdata[6], "R2 self clear", 32'(obs.size()), 1);

        // R3: zero trigger alone
        obs.delete();
        wr(8'h80);
        run(4);
        chk(obs.size() == 1 && obs[0] == 16'h0000 && !reg_rdata[7], "R3 zero frame",
            obs.size() > 0 ? 32'(obs[0]) : 32'hDEAD, 0);

        // R4: both together
        obs.delete();
        wr(8'hC0);
        run(8);
        chk(obs.size() == 2 && obs[0] == 16'hFFFF && obs[1] == 16'h0000, "R4 order",
            32'(obs.size()), 2);
        chk(reg_rdata[7:6] == 2'b00, "R4 both cleared", 32'(reg_rdata), 0);

        // R6: watermark-driven automatic pause
        obs.delete();
        wr(8'h20);
        rx_hi_wm = 1; run(12);
        chk(obs.size() == 1 && obs[0] == 16'hFFFF, "R6 single xoff", 32'(obs.size()), 1);
        rx_hi_wm = 0; rx_lo_wm = 1; run(12);
        chk(obs.size() == 2 && obs[1] == 16'h0000, "R6 single xon", 32'(obs.size()), 2);
        rx_lo_wm = 0; run(4);
        rx_hi_wm = 1; run(6); rx_hi_wm = 0; rx_lo_wm = 1; run(6); rx_lo_wm = 0;
        chk(obs.size() == 4 && obs[2] == 16'hFFFF && obs[3] == 16'h0000, "R6 second cycle",
            32'(obs.size()), 4);
        wr(8'h00);

        // R7 and R8: received pause and countdown
        wr(8'h01);
        rx_pause(16'd3);
        chk(reg_rdata[1] && reg_rdata[2] && tx_halt, "R7 R8 pause received", 32'(reg_rdata), 32'h07);
        reg_rd_en = 1; step(); reg_rd_en = 0;
        chk(!reg_rdata[1], "R7 read clears", 32'(reg_rdata[1]), 0);
        repeat (5) tick();
        chk(tx_halt == 1, "R8 still halted after 5 ticks", 32'(tx_halt), 1);
        tick();
        chk(tx_halt == 0 && !reg_rdata[2], "R8 release after quanta*PRESCALE ticks", 32'(tx_halt), 0);

        rx_pause_valid = 1; rx_pause_quanta = 16'd10; reg_rd_en = 1; step();
        rx_pause_valid = 0; reg_rd_en = 0;
        chk(reg_rdata[1] == 1, "R7 set wins over read", 32'(reg_rdata[1]), 1);
        tick();
        rx_pause(16'd2);
        repeat (3) tick();
        chk(tx_halt == 1, "R8 reload", 32'(tx_halt), 1);
        tick();
        chk(tx_halt == 0, "R8 reload count ends", 32'(tx_halt), 0);

        rx_pause(16'd10);
        rx_pause(16'd0);
        chk(!tx_halt && !reg_rdata[2], "R9 zero releases", 32'(tx_halt), 0);

        wr(8'h00);
        rx_pause(16'd4);
        chk(!tx_halt && reg_rdata[2], "R8 no halt without flow enable", 32'(tx_halt), 0);
        rx_pause(16'd0);

        // R10, R11, R12: half duplex
        half_duplex = 1; obs.delete();
        wr(8'h40);
        run(5);
        chk(obs.size() == 0 && !tx_pause_req, "R10 no pause in half duplex", 32'(tx_pause_req), 0);
        wr(8'h10);
        rx_bp_hi = 1; rx_frame_start = 1; step(); rx_frame_start = 0;
        chk(jam_req == 1, "R11 jam on any frame", 32'(jam_req), 1);
        step();
        chk(jam_req == 0, "R11 one-cycle strobe", 32'(jam_req), 0);
        rx_bp_hi = 0; rx_frame_start = 1; step(); rx_frame_start = 0;
        chk(jam_req == 0, "R11 no jam below threshold", 32'(jam_req), 0);
        wr(8'h08);
        rx_bp_hi = 1; rx_frame_start = 1; step(); rx_frame_start = 0;
        chk(jam_req == 0, "R12 frame start ignored", 32'(jam_req), 0);
        rx_da_match = 1; step(); rx_da_match = 0;
        chk(jam_req == 1, "R12 jam on address match", 32'(jam_req), 1);
        half_duplex = 0;
        rx_da_match = 1; step(); rx_da_match = 0;
        chk(jam_req == 0, "R10 no jam in full duplex", 32'(jam_req), 0);
        run(4);
        chk(obs.size() == 1 && obs[0] == 16'hFFFF, "R10 pending sent after duplex change",
            32'(obs.size()), 1);
        rx_bp_hi = 0;
        run(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule